// File: doc/BRIEF.md
# Parallel Flash Configuration Master

This block reads a configuration bitstream out of an external parallel NOR flash, acting as the master on the flash bus. After an asynchronous active-low program input is released, it waits on a hold-off line. That line is the open-drain node that other devices can pull low. As soon as the line reads high, the block samples the three mode pins once. Two codes start a read: code 010 reads ascending addresses and code 011 reads descending addresses. Any other code leaves the block parked with the flash pins released.

During the read phase the block drives the flash enables active and walks a 26-bit address. On every rising edge of its own clock that the downstream side can accept, it captures one data word and presents it on a ready/valid stream. The flash itself is not clocked; it only sees the address and enables. The read phase ends when the downstream logic raises a done input or when a programmable word count has been captured. At that point every flash output is released to high impedance, which is modelled as a pin-enable output going low.

After the mode sample, the hold-off line turns into a status output. A CRC error result pulls it low, and it stays low until the next program pulse.

Top module: `pfcm_top`

## Requirements
- R1: The mode pins are sampled once, on the first clock edge at which `initIn` is high after reset. Code 3'b010 starts an ascending read at address 0. Code 3'b011 starts a descending read at address 26'h3FFFFFF. Any other code parks the block with `flashPinEn` low. Later changes on the mode pins have no effect.
- R2: While `initIn` stays low after reset, no read starts: `flashPinEn` stays 0 and `outValid` stays 0.
- R3: For the whole read phase, `flashPinEn`=1, `flashCeN`=0, `flashOeN`=0 and `flashWeN`=1.
- R4: The address moves by exactly one for each captured word: it increments in ascending mode and decrements in descending mode. It does not change when no word is captured.
- R5: With `wide16`=1 a captured word is all 16 data bits. With `wide16`=0 it is data bits 7:0 in `outData[7:0]`, with `outData[15:8]`=0.
- R6: A word is captured only when the output slot is empty or is being emptied by `outReady` in that cycle. While `outValid`=1 and `outReady`=0, `outValid` and `outData` hold.
- R7: The read phase ends in either of two ways. If `doneIn` is high during the read phase, no word is captured in that cycle and the phase ends. If `wordLimit` is non-zero, the phase ends at the capture of word number `wordLimit`. After the end, `flashPinEn` is 0 and stays 0 until reset.
- R8: `initDrvLow` is 0 from reset until the mode pins are sampled. CRC results presented before that are ignored.
- R9: After the mode sample, a cycle with `crcValid`=1 and `crcOk`=0 sets `initDrvLow` to 1 from the next cycle. It stays 1 until `progN` goes low.
- R10: `progN` low resets the block asynchronously: `flashPinEn` drops at once, and the block returns to waiting on `initIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; also paces captures |
| progN | input | 1 | Asynchronous active-low program/reset |
| modePins | input | 3 | Mode code, sampled once |
| initIn | input | 1 | Level sensed on the hold-off line |
| initDrvLow | output | 1 | Pull the hold-off line low (CRC error) |
| crcValid | input | 1 | CRC result present this cycle |
| crcOk | input | 1 | CRC result: 1 = pass |
| doneIn | input | 1 | Ends the read phase |
| wordLimit | input | 27 | Words to read; 0 = no limit |
| wide16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus; change only under reset |
| flashData | input | 16 | Flash read data |
| flashAddr | output | 26 | Flash address |
| flashCeN | output | 1 | Chip select, active low |
| flashOeN | output | 1 | Output enable, active low |
| flashWeN | output | 1 | Write enable, active low (held high) |
| flashPinEn | output | 1 | 1 = flash outputs driven, 0 = high impedance |
| outData | output | 16 | Captured word |
| outValid | output | 1 | Captured word available |
| outReady | input | 1 | Downstream accepts the word |

## Verification
The bench targets four kinds of error. The first is mode codes that change after the sample: a design that samples the pins continuously would flip direction or start late. The second is the descending start at all ones: an off-by-one shows up as a wrong first address and as the data that belongs to it. The third is back-pressure under a broken handshake, which shows up as a dropped or repeated word and as an address that moves without a capture. The fourth is the two ways the read can end and the CRC status. Here the bench looks for pins that stay driven after done, a word captured in the cycle `doneIn` is high, a CRC result accepted before the mode sample, and an error flag that clears on its own.

// File: rtl/pfcm_pkg.sv
package pfcm_pkg;
  localparam logic [2:0] MODE_ASCEND  = 3'b010;
  localparam logic [2:0] MODE_DESCEND = 3'b011;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_READ = 2'd1,
    ST_DONE = 2'd2,
    ST_PARK = 2'd3
  } cfgState_t;

  typedef struct packed {
    logic loadAddr;  // load start address
    logic descend;   // address direction
    logic capture;   // take a word and step the address
    logic active;    // read phase, flash pins driven
  } ctrlStrobe_t;
endpackage

// File: rtl/pfcm_ctrl.sv
module pfcm_ctrl
  import pfcm_pkg::*;
#(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             progN,
  input  logic [2:0]       modePins,
  input  logic             initIn,
  input  logic             doneIn,
  input  logic [CNT_W-1:0] wordLimit,
  input  logic             crcValid,
  input  logic             crcOk,
  input  logic             slotFree,
  output ctrlStrobe_t      strobe,
  output logic             crcErr
);
  cfgState_t        state, stateNext;
  logic             descendQ;
  logic [CNT_W-1:0] wordCnt;
  logic             startNow, isUp, isDown, takeWord, lastWord;

  always_comb begin
    isUp     = (modePins == MODE_ASCEND);
    isDown   = (modePins == MODE_DESCEND);
    startNow = (state == ST_WAIT) && initIn;
    takeWord = (state == ST_READ) && !doneIn && slotFree;
    lastWord = (wordLimit != '0) && ((wordCnt + CNT_W'(1)) == wordLimit);

    stateNext = state;
    unique case (state)
      ST_WAIT: if (initIn) stateNext = (isUp || isDown) ? ST_READ : ST_PARK;
      ST_READ: if (doneIn || (takeWord && lastWord)) stateNext = ST_DONE;
      default: stateNext = state;
    endcase

    strobe.loadAddr = startNow && (isUp || isDown);
    strobe.descend  = startNow ? isDown : descendQ;
    strobe.capture  = takeWord;
    strobe.active   = (state == ST_READ);
  end

  always_ff @(posedge clk or negedge progN) begin
    if (!progN) begin
      state    <= ST_WAIT;
      descendQ <= 1'b0;
      wordCnt  <= '0;
      crcErr   <= 1'b0;
    end else begin
      state <= stateNext;
      if (strobe.loadAddr) begin
        descendQ <= isDown;
        wordCnt  <= '0;
      end else if (takeWord) begin
        wordCnt <= wordCnt + CNT_W'(1);
      end
      if ((state != ST_WAIT) && crcValid && !crcOk) crcErr <= 1'b1;
    end
  end
endmodule

// File: rtl/pfcm_datapath.sv
module pfcm_datapath
  import pfcm_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              progN,
  input  ctrlStrobe_t       strobe,
  input  logic              wide16,
  input  logic [DATA_W-1:0] flashData,
  input  logic              outReady,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              slotFree
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] wordIn;

  always_comb begin
    slotFree = !outValid || outReady;
    wordIn   = wide16 ? flashData
                      : {{(DATA_W - HALF_W){1'b0}}, flashData[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge progN) begin
    if (!progN) begin
      addr     <= '0;
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      if (strobe.loadAddr)
        addr <= strobe.descend ? {ADDR_W{1'b1}} : '0;
      else if (strobe.capture)
        addr <= strobe.descend ? addr - ADDR_W'(1) : addr + ADDR_W'(1);

      if (strobe.capture) begin
        outData  <= wordIn;
        outValid <= 1'b1;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pfcm_top.sv
module pfcm_top
  import pfcm_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              progN,
  input  logic [2:0]        modePins,
  input  logic              initIn,
  output logic              initDrvLow,
  input  logic              crcValid,
  input  logic              crcOk,
  input  logic              doneIn,
  input  logic [CNT_W-1:0]  wordLimit,
  input  logic              wide16,
  input  logic [DATA_W-1:0] flashData,
  output logic [ADDR_W-1:0] flashAddr,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic              flashWeN,
  output logic              flashPinEn,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady
);
  ctrlStrobe_t strobe;
  logic        slotFree;
  logic        crcErr;

  pfcm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .progN(progN), .modePins(modePins), .initIn(initIn),
    .doneIn(doneIn), .wordLimit(wordLimit), .crcValid(crcValid),
    .crcOk(crcOk), .slotFree(slotFree), .strobe(strobe), .crcErr(crcErr)
  );

  pfcm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .progN(progN), .strobe(strobe), .wide16(wide16),
    .flashData(flashData), .outReady(outReady), .addr(flashAddr),
    .outData(outData), .outValid(outValid), .slotFree(slotFree)
  );

  assign flashPinEn = strobe.active;
  assign flashCeN   = !strobe.active;
  assign flashOeN   = !strobe.active;
  assign flashWeN   = 1'b1;
  assign initDrvLow = crcErr;
endmodule

// File: rtl/pfcm_checker.sv
module pfcm_checker #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              progN,
  input logic              capture,
  input logic              descend,
  input logic              pinEn,
  input logic [ADDR_W-1:0] addr,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic              initDrvLow
);
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!progN)
    capture |=> addr == ($past(descend) ? $past(addr) - ADDR_W'(1)
                                        : $past(addr) + ADDR_W'(1)));

  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!progN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_no_capture_full_R6: assert property (@(posedge clk) disable iff (!progN)
    (outValid && !outReady) |-> !capture);

  assert_pins_stay_off_R7: assert property (@(posedge clk) disable iff (!progN)
    $fell(pinEn) |=> !pinEn);

  assert_capture_only_active_R3: assert property (@(posedge clk) disable iff (!progN)
    capture |-> pinEn);

  assert_crc_sticky_R9: assert property (@(posedge clk) disable iff (!progN)
    initDrvLow |=> initDrvLow);
endmodule

bind pfcm_top pfcm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .progN(progN), .capture(strobe.capture), .descend(strobe.descend),
  .pinEn(flashPinEn), .addr(flashAddr), .outValid(outValid),
  .outReady(outReady), .outData(outData), .initDrvLow(initDrvLow)
);

// File: tb/pfcm_top_tb.sv
module pfcm_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        progN, initIn, crcValid, crcOk, doneIn, wide16, outReady;
  logic [2:0]  modePins;
  logic [26:0] wordLimit;
  logic [15:0] flashData, outData;
  logic [25:0] flashAddr;
  logic        initDrvLow, flashCeN, flashOeN, flashWeN, flashPinEn, outValid;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] fdata(logic [25:0] a);
    return a[15:0] ^ {a[25:18], 8'h00} ^ 16'h5A3C;
  endfunction

  assign flashData = fdata(flashAddr);

  pfcm_top u_dut (
    .clk(clk), .progN(progN), .modePins(modePins), .initIn(initIn),
    .initDrvLow(initDrvLow), .crcValid(crcValid), .crcOk(crcOk),
    .doneIn(doneIn), .wordLimit(wordLimit), .wide16(wide16),
    .flashData(flashData), .flashAddr(flashAddr), .flashCeN(flashCeN),
    .flashOeN(flashOeN), .flashWeN(flashWeN), .flashPinEn(flashPinEn),
    .outData(outData), .outValid(outValid), .outReady(outReady)
  );

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 waiting, 1 reading, 2 finished, 3 parked
  int          ph;
  logic [25:0] mAddr;
  logic        mDesc, mV, mCrc, free, cap;
  logic [15:0] mD, rawW;
  int          mCnt, oldPh;

  always @(posedge clk or negedge progN) begin
    if (!progN) begin
      ph = 0; mAddr = '0; mDesc = 0; mV = 0; mD = '0; mCnt = 0; mCrc = 0;
    end else begin
      oldPh = ph;
      free  = !mV || outReady;
      cap   = (oldPh == 1) && !doneIn && free;
      if (oldPh != 0 && crcValid && !crcOk) mCrc = 1;
      if (cap) begin
        rawW = fdata(mAddr);
        mD   = wide16 ? rawW : {8'h00, rawW[7:0]};
        mV   = 1;
        mAddr = mDesc ? mAddr - 26'd1 : mAddr + 26'd1;
        mCnt++;
      end else if (outReady) mV = 0;
      case (oldPh)
        0: if (initIn) begin
             if (modePins == 3'b010)      begin ph = 1; mDesc = 0; mAddr = '0; mCnt = 0; end
             else if (modePins == 3'b011) begin ph = 1; mDesc = 1; mAddr = '1; mCnt = 0; end
             else ph = 3;
           end
        1: if (doneIn) ph = 2;
           else if (cap && wordLimit != 0 && mCnt == int'(wordLimit)) ph = 2;
        default: ;
      endcase
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    string pt;
    if (!finished) begin
      pt = (ph == 1) ? "R3" : (ph == 0) ? "R2" : (ph == 3) ? "R1" : "R7";
      chk(flashPinEn === (ph == 1), pt, "flashPinEn", 32'(flashPinEn), 32'(ph == 1));
      chk(flashCeN === (ph != 1), pt, "flashCeN", 32'(flashCeN), 32'(ph != 1));
      chk(flashOeN === (ph != 1), pt, "flashOeN", 32'(flashOeN), 32'(ph != 1));
      if (ph == 1) chk(flashWeN === 1'b1, "R3", "flashWeN", 32'(flashWeN), 32'd1);
      chk(flashAddr === mAddr, "R4", "flashAddr", 32'(flashAddr), 32'(mAddr));
      chk(outValid === mV, "R6", "outValid", 32'(outValid), 32'(mV));
      if (mV) chk(outData === mD, "R5", "outData", 32'(outData), 32'(mD));
      chk(initDrvLow === mCrc, mCrc ? "R9" : "R8", "initDrvLow",
          32'(initDrvLow), 32'(mCrc));
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic pulseReset();
    progN = 0;
    #1;
    chk(flashPinEn === 1'b0, "R10", "flashPinEn async", 32'(flashPinEn), 32'd0);
    chk(outValid === 1'b0, "R10", "outValid async", 32'(outValid), 32'd0);
    step(1);
    progN = 1;
  endtask

  task automatic summary();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    progN = 0; initIn = 0; modePins = 3'b010; wide16 = 1; doneIn = 0;
    wordLimit = '0; crcValid = 0; crcOk = 1; outReady = 1;
    #1;
    chk(flashPinEn === 1'b0, "R10", "reset flashPinEn", 32'(flashPinEn), 32'd0);
    chk(initDrvLow === 1'b0, "R8", "reset initDrvLow", 32'(initDrvLow), 32'd0);
    step(3);
    progN = 1;

    // R2/R8: held off, CRC error result ignored while waiting
    crcValid = 1; crcOk = 0;
    step(5);
    crcValid = 0; crcOk = 1;
    // R1: code sampled on release; descending starts at all ones
    modePins = 3'b011; wordLimit = 27'd5; initIn = 1;
    step(1);
    chk(flashAddr === 26'h3FFFFFF, "R1", "descend start", 32'(flashAddr), 32'h3FFFFFF);
    modePins = 3'b000;  // must not matter
    step(12);
    chk(flashPinEn === 1'b0, "R7", "limit end", 32'(flashPinEn), 32'd0);

    // 8-bit ascending, back-pressure, CRC error, done input
    pulseReset();
    wide16 = 0; modePins = 3'b010; wordLimit = '0;
    for (int i = 0; i < 32; i++) begin
      outReady = (i % 3) != 0;
      crcValid = (i == 10); crcOk = (i != 10);
      doneIn   = (i >= 25);
      step(1);
    end
    crcValid = 0; crcOk = 1; doneIn = 0; outReady = 1;
    step(3);
    chk(initDrvLow === 1'b1, "R9", "sticky error", 32'(initDrvLow), 32'd1);

    // R1: unsupported code parks
    pulseReset();
    modePins = 3'b101; wide16 = 1;
    step(5);
    chk(flashPinEn === 1'b0, "R1", "parked", 32'(flashPinEn), 32'd0);

    // 16-bit, stall then drain, passing CRC
    pulseReset();
    modePins = 3'b010; wordLimit = 27'd3; outReady = 0;
    step(5);
    crcValid = 1; crcOk = 1; outReady = 1;
    step(1);
    crcValid = 0;
    step(8);

    // R10: asynchronous reset in the middle of a read
    pulseReset();
    wordLimit = '0;
    step(6);
    pulseReset();
    initIn = 0;
    step(4);
    chk(flashPinEn === 1'b0, "R2", "wait after reset", 32'(flashPinEn), 32'd0);
    summary();
  end
endmodule